// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers interrupt requests from up to 32 peripheral sources and merges them into one interrupt line toward the host processor. Each request pulse is latched as a pending bit. A per-source enable register decides which pending bits may raise the merged line. When the host acknowledges, the block captures the vector number of the winning source, and the host then reads that number back to pick a handler.

Among sources, priority is fixed by vector number, with the higher number winning. The top four vectors form a group of serial channels, and the host can reorder them through a slot field. A promote field can lift any single source above all others. Vector 0 is reserved for errors. It is flagged when a source requests in the same cycle that its enable bit is being cleared. It is also what an acknowledge returns when nothing valid is waiting.

The host reaches four registers over a simple write-strobe bus with a combinational read port. Register select values are 0 for config, 1 for mask, 2 for status and 3 for vector.

Top module: `pic_vec_ctrl`

## Requirements
- R1: After reset, irq_o is 0. Status, mask and vector read 0. Config reads 0x001B0000, which places the slots in identity order.
- R2: A request on req_i[n] (n ≥ 1) sets status bit n whatever the mask holds. The bit stays set until the host clears it.
- R3: Writing the status register clears every bit written as 1. A request that arrives in the same cycle as the clear of its own bit leaves that bit set. Status bit 0 is the error-pending flag.
- R4: irq_o is registered. It reflects the state one clock after that state changes. It equals config bit 7 (global enable) AND (status bit 0 OR any status[n] & mask[n] with n ≥ 1).
- R5: Mask bit n (n ≥ 1) lets pending source n take part in irq_o and in vector selection. The error flag is not masked.
- R6: A write to the vector register with bit 0 = 1 latches the winning vector. A read of that register returns the vector in bits 15:11 with every other bit 0. A write with bit 0 = 0 leaves the latched vector unchanged.
- R7: Without promotion, among active sources below the channel group the higher vector number wins. Every channel-group position outranks all of them.
- R8: Config bits 23:16 hold four 2-bit slots: A at 17:16, B at 19:18, C at 21:20 and D at 23:22. Slot A names the channel c (vector NUM_SRC-4+c) with the top rank, and slot D the lowest channel rank. A channel named by no slot can win only through promotion. A channel named twice takes its best rank.
- R9: Config bits 12:8 hold the promoted vector. When nonzero and that source is active, it wins over all others.
- R10: A mask write that clears bit n while req_i[n] is high in the same cycle sets status bit 0 as well as status bit n.
- R11: An acknowledge with no active source above vector 0 latches vector 0.
- R12: irq_level_o equals config bits 15:13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_SRC-1 | Request pulses, bit n for vector n (n ≥ 1) |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Merged interrupt to host |
| irq_level_o | output | 3 | Host interrupt level for irq_o |

## Verification
Two pairs of events can land in one edge: a request pulse with the write-one-to-clear of the same status bit, and a request pulse with the mask write that disables that source. The bench drives both in a single cycle. It then reads status back: the request bit must survive the clear, and the error flag must appear only when the masked bit matches the requesting source. A matching control case, with a request on a different source, must leave the error flag clear.

// File: rtl/pic_vec_pkg.sv
package pic_vec_pkg;
  localparam logic [1:0] A_CFG  = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_VEC  = 2'd3;

  localparam int VEC_LSB = 11;

  typedef struct packed {
    logic [7:0] slots;
    logic [2:0] lvl;
    logic [4:0] prom;
    logic       en;
  } cfg_t;

  localparam cfg_t CFG_RST = '{slots: 8'h1B, lvl: 3'd0, prom: 5'd0, en: 1'b0};

  function automatic cfg_t cfg_from_word(input logic [31:0] w);
    cfg_t c;
    c.slots = w[23:16];
    c.lvl   = w[15:13];
    c.prom  = w[12:8];
    c.en    = w[7];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input cfg_t c);
    return {8'h00, c.slots, c.lvl, c.prom, c.en, 7'h00};
  endfunction
endpackage

// File: rtl/pic_vec_pending.sv
module pic_vec_pending #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:1] req_i,
  input  logic               clr_we_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] mask_q_i,
  output logic [NUM_SRC-1:0] status_o
);
  logic [NUM_SRC-1:0] status_q, status_d, clr;
  logic               race;

  assign clr  = clr_we_i ? wdata_i : '0;
  // source requesting while its enable is being dropped
  assign race = mask_we_i & (|(mask_q_i[NUM_SRC-1:1] & ~wdata_i[NUM_SRC-1:1] & req_i));

  always_comb begin
    status_d             = status_q & ~clr;
    status_d[NUM_SRC-1:1] = status_d[NUM_SRC-1:1] | req_i;
    status_d[0]          = status_d[0] | race;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_o = status_q;
endmodule

// File: rtl/pic_vec_arbiter.sv
module pic_vec_arbiter #(
  parameter int NUM_SRC = 32,
  localparam int VW = $clog2(NUM_SRC),
  localparam int CB = NUM_SRC - 4
) (
  input  logic [NUM_SRC-1:1] active_i,
  input  logic [7:0]         slots_i,
  input  logic [VW-1:0]      prom_i,
  output logic [VW-1:0]      vec_o
);
  logic [VW-1:0] pos_src [1:NUM_SRC-1];

  // rank position p maps to a source; channel positions read the slot field
  for (genvar p = 1; p < NUM_SRC; p++) begin : g_pos
    if (p < CB) begin : g_fix
      assign pos_src[p] = VW'(p);
    end else begin : g_chan
      assign pos_src[p] = VW'(CB) + VW'(slots_i[2*(NUM_SRC-1-p) +: 2]);
    end
  end

  always_comb begin
    vec_o = '0;
    for (int p = 1; p < NUM_SRC; p++) begin
      if (active_i[pos_src[p]]) vec_o = pos_src[p];
    end
    if (prom_i != '0) begin
      if (active_i[prom_i]) vec_o = prom_i;
    end
  end
endmodule

// File: rtl/pic_vec_ctrl.sv
module pic_vec_ctrl
  import pic_vec_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int VW = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:1] req_i,
  input  logic               we_i,
  input  logic [1:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o,
  output logic [2:0]         irq_level_o
);
  cfg_t               cfg_q;
  logic [NUM_SRC-1:0] mask_q, status;
  logic [VW-1:0]      vec_q, win;
  logic               irq_q, glb_en;
  logic               cfg_we, mask_we, stat_we, ack;

  assign cfg_we  = we_i && addr_i == A_CFG;
  assign mask_we = we_i && addr_i == A_MASK;
  assign stat_we = we_i && addr_i == A_STAT;
  assign ack     = we_i && addr_i == A_VEC && wdata_i[0];
  assign glb_en  = cfg_q.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST;
      mask_q <= '0;
    end else begin
      if (cfg_we)  cfg_q  <= cfg_from_word(wdata_i);
      if (mask_we) mask_q <= wdata_i[NUM_SRC-1:0];
    end
  end

  pic_vec_pending #(.NUM_SRC(NUM_SRC)) u_pending (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .clr_we_i  (stat_we),
    .mask_we_i (mask_we),
    .wdata_i   (wdata_i[NUM_SRC-1:0]),
    .mask_q_i  (mask_q),
    .status_o  (status)
  );

  pic_vec_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .active_i (status[NUM_SRC-1:1] & mask_q[NUM_SRC-1:1]),
    .slots_i  (cfg_q.slots),
    .prom_i   (cfg_q.prom[VW-1:0]),
    .vec_o    (win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (ack) vec_q <= win;
      irq_q <= glb_en & (status[0] | (|(status[NUM_SRC-1:1] & mask_q[NUM_SRC-1:1])));
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CFG:   rdata_o = cfg_to_word(cfg_q);
      A_MASK:  rdata_o = 32'(mask_q);
      A_STAT:  rdata_o = 32'(status);
      default: rdata_o = 32'(5'(vec_q)) << VEC_LSB;
    endcase
  end

  assign irq_o       = irq_q;
  assign irq_level_o = cfg_q.lvl;
endmodule

// File: rtl/pic_vec_chk.sv
module pic_vec_chk
  import pic_vec_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int VW = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:1] req_i,
  input logic               we_i,
  input logic [1:0]         addr_i,
  input logic [31:0]        wdata_i,
  input logic [31:0]        rdata_o,
  input logic               irq_o,
  input logic               glb_en,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [VW-1:0]      vec_q
);
  assert_req_latched_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> ((status[NUM_SRC-1:1] & $past(req_i)) == $past(req_i)));

  assert_irq_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en |=> !irq_o);

  assert_vec_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == A_VEC && wdata_i[0]) |=> $stable(vec_q));

  assert_vec_field_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_VEC) |-> (rdata_o[10:0] == '0 && rdata_o[31:16] == '0));

  assert_race_err_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_MASK &&
     (|(mask_q[NUM_SRC-1:1] & ~wdata_i[NUM_SRC-1:1] & req_i))) |=> status[0]);
endmodule

bind pic_vec_ctrl pic_vec_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .glb_en  (glb_en),
  .status  (status),
  .mask_q  (mask_q),
  .vec_q   (vec_q)
);

// File: tb/pic_vec_ctrl_bench.sv
module pic_vec_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int CB = N - 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:1]  req = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  logic [2:0]    lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_vec_ctrl #(.NUM_SRC(N)) u_pic_vec_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .irq_level_o(lvl)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input int p);
    req = p[N-1:1];
    tick();
    req = '0;
  endtask

  function automatic int cfgw(input int en, input int lv, input int pr, input int sl);
    return (sl << 16) | (lv << 13) | (pr << 8) | (en << 7);
  endfunction

  // reference rank model: promoted 1000, channel by best slot, unlisted -1
  function automatic int exp_vec(input int pend, input int msk, input int sl, input int pr);
    int best = -1;
    int bv = 0;
    for (int s = 1; s < N; s++) begin
      int r;
      if (!(pend[s] && msk[s])) continue;
      if (s < CB) r = s;
      else begin
        r = -1;
        for (int k = 3; k >= 0; k--) if (((sl >> (2*k)) & 3) == s - CB) r = CB + 3 - k;
      end
      if (pr != 0 && s == pr) r = 1000;
      if (r > best) begin best = r; bv = s; end
    end
    return bv;
  endfunction

  task automatic ack_check(input int e, input string r);
    logic [31:0] d;
    wr(2'd3, 32'h1);
    rd(2'd3, d);
    chk(d == 32'(e << 11), r, d, e << 11);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    rd(2'd0, d); chk(d == 32'h001B0000, "R1", d, 32'h001B0000);
    rd(2'd1, d); chk(d == 0, "R1", d, 0);
    rd(2'd2, d); chk(d == 0, "R1", d, 0);
    rd(2'd3, d); chk(d == 0, "R1", d, 0);
    chk(irq == 0, "R1", irq, 0);

    // R12 level field
    for (int l = 0; l < 8; l++) begin
      wr(2'd0, cfgw(0, l, 0, 8'h1B));
      chk(lvl == 3'(l), "R12", lvl, l);
    end

    // R4 global enable gating
    wr(2'd0, cfgw(0, 0, 0, 8'h1B));
    wr(2'd1, 32'hFF);
    pulse(8'h80);
    tick(); tick();
    chk(irq == 0, "R4", irq, 0);
    wr(2'd0, cfgw(1, 0, 0, 8'h1B));
    tick();
    chk(irq == 1, "R4", irq, 1);
    wr(2'd2, 32'hFF);

    // R2 R4 R7 R11 R3: full pending sweep, all enabled
    for (int p = 0; p < 256; p += 2) begin
      pulse(p);
      rd(2'd2, d); chk(d == 32'(p), "R2", d, p);
      tick();
      chk(irq == (p != 0), "R4", irq, p != 0);
      ack_check(exp_vec(p, 8'hFF, 8'h1B, 0), p == 0 ? "R11" : "R7");
      wr(2'd2, 32'hFF);
      rd(2'd2, d); chk(d == 0, "R3", d, 0);
    end

    // R5 mask sweep with all sources pending
    pulse(8'hFE);
    for (int m = 0; m < 256; m++) begin
      wr(2'd1, 32'(m));
      tick();
      chk(irq == ((m & 8'hFE) != 0), "R5", irq, (m & 8'hFE) != 0);
      ack_check(exp_vec(8'hFE, m, 8'h1B, 0), "R5");
    end
    rd(2'd2, d); chk(d == 32'hFE, "R2", d, 32'hFE);
    // R6 write without ack bit keeps vector
    wr(2'd1, 32'hFF);
    wr(2'd3, 32'h0);
    rd(2'd3, d); chk(d == 32'(7 << 11), "R6", d, 7 << 11);
    wr(2'd2, 32'hFF);
    wr(2'd3, 32'h2);
    rd(2'd3, d); chk(d == 32'(7 << 11), "R6", d, 7 << 11);

    // R8 slot mapping sweep
    for (int sl = 0; sl < 256; sl++) begin
      wr(2'd0, cfgw(1, 0, 0, sl));
      for (int sub = 0; sub < 16; sub++) begin
        pulse((sub << 4) | 2);
        ack_check(exp_vec((sub << 4) | 2, 8'hFF, sl, 0), "R8");
        wr(2'd2, 32'hFF);
      end
    end

    // R9 promotion sweep
    for (int pr = 0; pr < N; pr++) begin
      wr(2'd0, cfgw(1, 0, pr, 8'h1B));
      for (int p = 0; p < 256; p += 2) begin
        pulse(p);
        ack_check(exp_vec(p, 8'hFF, 8'h1B, pr), "R9");
        wr(2'd2, 32'hFF);
      end
    end
    wr(2'd0, cfgw(1, 0, 0, 8'h1B));

    // R10 race: mask clear of bit 3 with request on 3
    wr(2'd1, 32'hFF);
    req = 7'(8'h08 >> 1); we = 1'b1; addr = 2'd1; wdata = 32'hF7;
    tick();
    we = 1'b0; req = '0;
    rd(2'd2, d); chk(d == 32'h09, "R10", d, 32'h09);
    wr(2'd1, 32'h00);
    tick();
    chk(irq == 1, "R5", irq, 1);
    ack_check(0, "R10");
    wr(2'd2, 32'h09);
    tick(); tick();
    chk(irq == 0, "R3", irq, 0);
    // control: different source requesting during mask clear
    wr(2'd1, 32'hFF);
    req = 7'(8'h20 >> 1); we = 1'b1; addr = 2'd1; wdata = 32'hF7;
    tick();
    we = 1'b0; req = '0;
    rd(2'd2, d); chk(d == 32'h20, "R10", d, 32'h20);
    wr(2'd2, 32'hFF);

    // R3 set wins over same-cycle clear
    pulse(8'h04);
    req = 7'(8'h04 >> 1); we = 1'b1; addr = 2'd2; wdata = 32'h04;
    tick();
    we = 1'b0; req = '0;
    rd(2'd2, d); chk(d == 32'h04, "R3", d, 32'h04);
    req = 7'(8'h20 >> 1); we = 1'b1; addr = 2'd2; wdata = 32'h04;
    tick();
    we = 1'b0; req = '0;
    rd(2'd2, d); chk(d == 32'h20, "R3", d, 32'h20);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule